// File: doc/BRIEF.md
# Linked-List DMA Descriptor Sequencer

This block is the descriptor engine of one DMA channel running multi-buffer transfers. Software starts a chain by writing the address of the first descriptor into the pointer input. Before every buffer the block reads a five-word descriptor from system memory through a single-outstanding word master port. It loads the words into the channel register outputs and pulses a start strobe to an external data mover. When the mover reports completion, the block writes the mover's updated control A word back into the descriptor. It then follows the next pointer, or ends the chain if that pointer is zero.

For every buffer after the first, each register group can take its value from a different source. Source and destination addresses come from the fetched descriptor, are replayed from the previous buffer, or continue from the end addresses the mover reports. The two control words come from the descriptor or are replayed. The pointer to the next descriptor is always taken from memory. The first buffer of a chain always loads every group from its descriptor, so stale register contents have no effect.

Top module: `ll_dma_seq`

## Requirements
- R1: After reset, `busy`, `chain_done`, `mv_start` and `mem_req` are all 0.
- R2: A pointer write starts a chain only when the block is idle and the aligned pointer is nonzero. A write of zero causes no memory access and leaves `busy` at 0. A write while busy does not change the running chain.
- R3: The two low bits of every descriptor pointer are treated as zero, both the written one and the fetched one, so every memory access address has bits [1:0] equal to 0.
- R4: Each descriptor is fetched as five single-cycle read requests in this order, at byte offsets from the pointer: source 0x0, destination 0x4, control A 0x8, control B 0xC, next pointer 0x10. A new request is issued only after the `mem_valid` of the previous one.
- R5: When `mv_start` is high, the channel outputs hold the values chosen for that buffer. The first buffer of a chain takes all of them from its descriptor, whatever the mode inputs are.
- R6: `mv_start` is a one-cycle pulse, issued exactly once per buffer after its fetch completes. The next buffer's start waits for `mv_done`.
- R7: After `mv_done`, one write request with `mem_we`=1 carries the mover's `mv_ctla` value to the current descriptor's address plus 0x8.
- R8: When the write-back completes, a nonzero fetched next pointer starts a fetch at that address. A zero next pointer ends the chain: `busy` falls and `chain_done` pulses for one cycle.
- R9: With `src_mode` or `dst_mode` at 2'b01 (replay), the matching address of a later buffer repeats the previous buffer's value, and the fetched word is ignored. 2'b00 and 2'b11 select the descriptor.
- R10: With `src_mode` or `dst_mode` at 2'b10 (contiguous), the matching address of a later buffer equals `mv_src_end` or `mv_dst_end` reported at the previous `mv_done`.
- R11: With `ctl_mode`=1 (replay), control A and control B of a later buffer repeat the previous buffer's values. With `ctl_mode`=0 they come from the descriptor.
- R12: `busy` rises in the cycle after an accepted pointer write and stays high until the chain ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ptr_wr | input | 1 | Software write strobe for the first-descriptor pointer |
| ptr_wdata | input | ADDR_W | Pointer value written |
| src_mode | input | 2 | Source address reload: 00 descriptor, 01 replay, 10 contiguous, 11 descriptor |
| dst_mode | input | 2 | Destination address reload, same encoding |
| ctl_mode | input | 1 | Control word reload: 0 descriptor, 1 replay |
| mem_req | output | 1 | One-cycle memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Request byte address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid with mem_valid |
| mem_valid | input | 1 | Read data or write completion |
| ch_src | output | ADDR_W | Channel source address |
| ch_dst | output | ADDR_W | Channel destination address |
| ch_next | output | ADDR_W | Channel next-descriptor pointer |
| ch_ctla | output | DATA_W | Channel control A |
| ch_ctlb | output | DATA_W | Channel control B |
| mv_start | output | 1 | Start pulse to the data mover |
| mv_done | input | 1 | Mover finished the buffer |
| mv_src_end | input | ADDR_W | Source address after the buffer |
| mv_dst_end | input | ADDR_W | Destination address after the buffer |
| mv_ctla | input | DATA_W | Updated control A to write back |
| busy | output | 1 | Chain in progress |
| chain_done | output | 1 | One-cycle pulse at chain end |

## Verification
The bench builds the block with ADDR_W=16 and DATA_W=32, so each fetched 32-bit word is cut to a narrower address. This tests the slicing and the alignment masking on a width that differs from the data word. The 16-bit address space lets a small modelled memory hold several chained descriptors at once. The memory answers two cycles after each request and the mover takes three cycles, so every wait state of the sequencer is visited.

// File: rtl/ll_dma_seq.sv
module ll_dma_seq #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ptr_wr,
  input  logic [ADDR_W-1:0] ptr_wdata,
  input  logic [1:0]        src_mode,
  input  logic [1:0]        dst_mode,
  input  logic              ctl_mode,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_valid,
  output logic [ADDR_W-1:0] ch_src,
  output logic [ADDR_W-1:0] ch_dst,
  output logic [ADDR_W-1:0] ch_next,
  output logic [DATA_W-1:0] ch_ctla,
  output logic [DATA_W-1:0] ch_ctlb,
  output logic              mv_start,
  input  logic              mv_done,
  input  logic [ADDR_W-1:0] mv_src_end,
  input  logic [ADDR_W-1:0] mv_dst_end,
  input  logic [DATA_W-1:0] mv_ctla,
  output logic              busy,
  output logic              chain_done
);
  localparam int          NWORDS = 5;
  localparam int          IDX_W  = $clog2(NWORDS);
  localparam logic [1:0]  MODE_REPLAY = 2'b01;
  localparam logic [1:0]  MODE_CONTIG = 2'b10;
  localparam logic [ADDR_W-1:0] ALIGN = ~ADDR_W'(3);
  localparam logic [ADDR_W-1:0] WB_OFS = ADDR_W'(8);
  localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(NWORDS - 1);

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_RUN, S_WAIT, S_WB} state_t;

  state_t            state;
  logic [IDX_W-1:0]  idx;
  logic              pend;
  logic              first;
  logic [ADDR_W-1:0] cur_desc;
  logic [DATA_W-1:0] wb_data;

  logic [ADDR_W-1:0] ptr_aligned;
  logic [ADDR_W-1:0] rd_addr;
  logic              take_src, take_dst, take_ctl;

  assign ptr_aligned = ptr_wdata & ALIGN;
  assign rd_addr     = cur_desc + ADDR_W'({idx, 2'b00});
  assign take_src    = first || !(src_mode == MODE_REPLAY || src_mode == MODE_CONTIG);
  assign take_dst    = first || !(dst_mode == MODE_REPLAY || dst_mode == MODE_CONTIG);
  assign take_ctl    = first || !ctl_mode;
  assign busy        = (state != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      idx        <= '0;
      pend       <= 1'b0;
      first      <= 1'b0;
      cur_desc   <= '0;
      wb_data    <= '0;
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      ch_src     <= '0;
      ch_dst     <= '0;
      ch_next    <= '0;
      ch_ctla    <= '0;
      ch_ctlb    <= '0;
      mv_start   <= 1'b0;
      chain_done <= 1'b0;
    end else begin
      chain_done <= 1'b0;
      mv_start   <= 1'b0;
      mem_req    <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (ptr_wr && ptr_aligned != '0) begin
            cur_desc <= ptr_aligned;
            first    <= 1'b1;
            idx      <= '0;
            pend     <= 1'b0;
            state    <= S_FETCH;
          end
        end
        S_FETCH: begin
          if (!pend) begin
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= rd_addr;
            pend     <= 1'b1;
          end else if (mem_valid) begin
            pend <= 1'b0;
            case (idx)
              IDX_W'(0): if (take_src) ch_src  <= mem_rdata[ADDR_W-1:0];
              IDX_W'(1): if (take_dst) ch_dst  <= mem_rdata[ADDR_W-1:0];
              IDX_W'(2): if (take_ctl) ch_ctla <= mem_rdata;
              IDX_W'(3): if (take_ctl) ch_ctlb <= mem_rdata;
              default:   ch_next <= mem_rdata[ADDR_W-1:0] & ALIGN;
            endcase
            if (idx == LAST_IDX) begin
              mv_start <= 1'b1;
              state    <= S_RUN;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        S_RUN: state <= S_WAIT;
        S_WAIT: begin
          if (mv_done) begin
            wb_data <= mv_ctla;
            if (src_mode == MODE_CONTIG) ch_src <= mv_src_end;
            if (dst_mode == MODE_CONTIG) ch_dst <= mv_dst_end;
            pend  <= 1'b0;
            state <= S_WB;
          end
        end
        S_WB: begin
          if (!pend) begin
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= cur_desc + WB_OFS;
            mem_wdata <= wb_data;
            pend      <= 1'b1;
          end else if (mem_valid) begin
            pend <= 1'b0;
            if (ch_next == '0) begin
              chain_done <= 1'b1;
              state      <= S_IDLE;
            end else begin
              cur_desc <= ch_next;
              first    <= 1'b0;
              idx      <= '0;
              state    <= S_FETCH;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ll_dma_seq_chk.sv
module ll_dma_seq_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ptr_wr,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mv_start,
  input logic              busy,
  input logic              chain_done
);
  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n) mem_req |-> mem_addr[1:0] == 2'b00); // R3
  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) mem_req |=> !mem_req); // R4
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n) mv_start |=> !mv_start); // R6
  AST_START_IN_CHAIN: assert property (@(posedge clk) disable iff (!rst_n) mv_start |-> busy); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) chain_done |=> !chain_done); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) chain_done |-> !busy); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (!mem_req && !mv_start)); // R2
  AST_BUSY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(ptr_wr)); // R12
endmodule

bind ll_dma_seq ll_dma_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ptr_wr(ptr_wr), .mem_req(mem_req), .mem_addr(mem_addr),
  .mv_start(mv_start), .busy(busy), .chain_done(chain_done)
);

// File: tb/tb_ll_dma_seq.sv
`timescale 1ns/1ps
module tb_ll_dma_seq;
  localparam int AW = 16;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          ptr_wr = 1'b0;
  logic [AW-1:0] ptr_wdata = '0;
  logic [1:0]    src_mode = 2'b00, dst_mode = 2'b00;
  logic          ctl_mode = 1'b0;
  logic          mem_req, mem_we, mem_valid;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic [AW-1:0] ch_src, ch_dst, ch_next, mv_src_end, mv_dst_end;
  logic [DW-1:0] ch_ctla, ch_ctlb, mv_ctla;
  logic          mv_start, mv_done, busy, chain_done;

  ll_dma_seq #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .ptr_wr(ptr_wr), .ptr_wdata(ptr_wdata),
    .src_mode(src_mode), .dst_mode(dst_mode), .ctl_mode(ctl_mode),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_valid(mem_valid),
    .ch_src(ch_src), .ch_dst(ch_dst), .ch_next(ch_next), .ch_ctla(ch_ctla), .ch_ctlb(ch_ctlb),
    .mv_start(mv_start), .mv_done(mv_done), .mv_src_end(mv_src_end), .mv_dst_end(mv_dst_end),
    .mv_ctla(mv_ctla), .busy(busy), .chain_done(chain_done)
  );

  int checks = 0;
  int errors = 0;

  logic [DW-1:0] mem [0:255];
  logic [AW-1:0] op_addr [0:255];
  logic          op_we   [0:255];
  logic [DW-1:0] op_data [0:255];
  int            op_n = 0;
  logic [DW-1:0] lg_src [0:63], lg_dst [0:63], lg_ctla [0:63], lg_ctlb [0:63];
  int            mv_n = 0;
  int            done_n = 0;
  int            mdly = 0, vdly = 0;
  logic [DW-1:0] rd_buf = '0;

  initial begin
    mem_valid = 1'b0; mem_rdata = '0;
    mv_done = 1'b0; mv_src_end = '0; mv_dst_end = '0; mv_ctla = '0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
  end

  always @(posedge clk) begin
    mem_valid <= 1'b0;
    if (mdly > 0) begin
      mdly <= mdly - 1;
      if (mdly == 1) begin
        mem_valid <= 1'b1;
        mem_rdata <= rd_buf;
      end
    end
    if (mem_req) begin
      op_addr[op_n[7:0]] <= mem_addr;
      op_we[op_n[7:0]]   <= mem_we;
      op_data[op_n[7:0]] <= mem_wdata;
      op_n <= op_n + 1;
      if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
      rd_buf <= mem[mem_addr[9:2]];
      mdly <= 2;
    end
  end

  always @(posedge clk) begin
    mv_done <= 1'b0;
    if (chain_done) done_n <= done_n + 1;
    if (vdly > 0) begin
      vdly <= vdly - 1;
      if (vdly == 1) begin
        mv_done    <= 1'b1;
        mv_src_end <= ch_src + AW'(ch_ctla[11:0]);
        mv_dst_end <= ch_dst + AW'(ch_ctla[11:0]);
        mv_ctla    <= ch_ctla | 32'h8000_0000;
      end
    end
    if (mv_start) begin
      lg_src[mv_n[5:0]]  <= DW'(ch_src);
      lg_dst[mv_n[5:0]]  <= DW'(ch_dst);
      lg_ctla[mv_n[5:0]] <= ch_ctla;
      lg_ctlb[mv_n[5:0]] <= ch_ctlb;
      mv_n <= mv_n + 1;
      vdly <= 3;
    end
  end

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_up();
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put_desc(input int base, input int s, input int d, input int ca,
                          input int cb, input int nxt);
    mem[(base >> 2) & 255]       = DW'(s);
    mem[((base >> 2) + 1) & 255] = DW'(d);
    mem[((base >> 2) + 2) & 255] = DW'(ca);
    mem[((base >> 2) + 3) & 255] = DW'(cb);
    mem[((base >> 2) + 4) & 255] = DW'(nxt);
  endtask

  task automatic kick(input int p);
    @(negedge clk);
    ptr_wr = 1'b1; ptr_wdata = AW'(p);
    @(negedge clk);
    ptr_wr = 1'b0;
  endtask

  task automatic wait_idle(input string tag);
    int n = 0;
    while (busy && n < 3000) begin
      @(negedge clk);
      n++;
    end
    check(!busy, tag, busy, 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic chk_fetch(input int o, input int base, input string tag);
    for (int k = 0; k < 5; k++) begin
      check(op_addr[(o + k) & 255] == AW'(base + 4 * k) && !op_we[(o + k) & 255], tag,
            op_addr[(o + k) & 255], base + 4 * k);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !chain_done && !mv_start && !mem_req, "R1 reset outputs",
          {busy, chain_done, mv_start, mem_req}, 0);
  endtask

  task automatic t_zero();
    int o = op_n;
    kick(0);
    repeat (10) @(negedge clk);
    check(!busy, "R2 zero write busy", busy, 0);
    check(op_n == o, "R2 zero write no access", op_n - o, 0);
  endtask

  task automatic t_single();
    int o = op_n, m = mv_n, dn = done_n;
    put_desc(32'h100, 32'h1000, 32'h2000, 32'h10, 32'h55, 0);
    kick(32'h103);
    check(busy, "R12 busy after write", busy, 1);
    wait_idle("R8 single chain ends");
    check(op_n - o == 6, "R4 op count", op_n - o, 6);
    chk_fetch(o, 32'h100, "R3 R4 fetch order/alignment");
    check(op_we[(o + 5) & 255] && op_addr[(o + 5) & 255] == 16'h108, "R7 wb address",
          op_addr[(o + 5) & 255], 32'h108);
    check(op_data[(o + 5) & 255] == 32'h8000_0010, "R7 wb data", op_data[(o + 5) & 255], 32'h8000_0010);
    check(mem[(32'h108 >> 2)] == 32'h8000_0010, "R7 memory updated", mem[32'h108 >> 2], 32'h8000_0010);
    check(mv_n - m == 1, "R6 one start", mv_n - m, 1);
    check(lg_src[m] == 32'h1000 && lg_dst[m] == 32'h2000, "R5 addresses at start",
          {lg_src[m], lg_dst[m]}, {32'h1000, 32'h2000});
    check(lg_ctla[m] == 32'h10 && lg_ctlb[m] == 32'h55, "R5 controls at start",
          {lg_ctla[m], lg_ctlb[m]}, {32'h10, 32'h55});
    check(done_n - dn == 1, "R8 chain_done once", done_n - dn, 1);
  endtask

  task automatic t_chain();
    int o = op_n, m = mv_n, dn = done_n;
    put_desc(32'h200, 32'h3000, 32'h4000, 32'h20, 32'h1, 32'h241);
    put_desc(32'h240, 32'h3100, 32'h4100, 32'h30, 32'h2, 32'h280);
    put_desc(32'h280, 32'h3200, 32'h4200, 32'h40, 32'h3, 0);
    put_desc(32'h300, 32'h5000, 32'h6000, 32'h50, 32'h4, 0);
    kick(32'h200);
    repeat (5) @(negedge clk);
    kick(32'h300);
    wait_idle("R8 chain of three ends");
    check(op_n - o == 18, "R2 busy write ignored, op count", op_n - o, 18);
    chk_fetch(o + 6, 32'h240, "R3 R8 follow next pointer");
    chk_fetch(o + 12, 32'h280, "R8 third fetch");
    check(op_addr[(o + 11) & 255] == 16'h248 && op_addr[(o + 17) & 255] == 16'h288,
          "R7 wb per descriptor", {op_addr[(o + 11) & 255], op_addr[(o + 17) & 255]}, {16'h248, 16'h288});
    check(mv_n - m == 3, "R6 three starts", mv_n - m, 3);
    check(lg_src[(m + 2) & 63] == 32'h3200 && lg_ctla[(m + 2) & 63] == 32'h40, "R5 third buffer",
          {lg_src[(m + 2) & 63], lg_ctla[(m + 2) & 63]}, {32'h3200, 32'h40});
    check(lg_src[(m + 1) & 63] == 32'h3100 && lg_dst[(m + 1) & 63] == 32'h4100, "R9 mode 00 loads descriptor",
          {lg_src[(m + 1) & 63], lg_dst[(m + 1) & 63]}, {32'h3100, 32'h4100});
    check(done_n - dn == 1, "R8 one chain_done", done_n - dn, 1);
  endtask

  task automatic t_replay();
    int m = mv_n;
    src_mode = 2'b01; dst_mode = 2'b01; ctl_mode = 1'b1;
    put_desc(32'h140, 32'h7000, 32'h7800, 32'h18, 32'hAA, 32'h160);
    put_desc(32'h160, 32'h9999, 32'h8888, 32'h77, 32'hBB, 0);
    kick(32'h140);
    wait_idle("R8 replay chain ends");
    check(lg_src[m] == 32'h7000 && lg_ctla[m] == 32'h18, "R5 first buffer ignores mode",
          {lg_src[m], lg_ctla[m]}, {32'h7000, 32'h18});
    check(lg_src[(m + 1) & 63] == 32'h7000 && lg_dst[(m + 1) & 63] == 32'h7800, "R9 replay addresses",
          {lg_src[(m + 1) & 63], lg_dst[(m + 1) & 63]}, {32'h7000, 32'h7800});
    check(lg_ctla[(m + 1) & 63] == 32'h18 && lg_ctlb[(m + 1) & 63] == 32'hAA, "R11 replay controls",
          {lg_ctla[(m + 1) & 63], lg_ctlb[(m + 1) & 63]}, {32'h18, 32'hAA});
    check(mem[32'h168 >> 2] == 32'h8000_0018, "R7 wb of replayed control", mem[32'h168 >> 2], 32'h8000_0018);
  endtask

  task automatic t_contig();
    int m = mv_n;
    src_mode = 2'b10; dst_mode = 2'b10; ctl_mode = 1'b0;
    put_desc(32'h180, 32'h1100, 32'h2200, 32'h24, 32'hC1, 32'h1A0);
    put_desc(32'h1A0, 32'h5555, 32'h6666, 32'h08, 32'hC2, 0);
    kick(32'h180);
    wait_idle("R8 contiguous chain ends");
    check(lg_src[(m + 1) & 63] == 32'h1124 && lg_dst[(m + 1) & 63] == 32'h2224, "R10 contiguous addresses",
          {lg_src[(m + 1) & 63], lg_dst[(m + 1) & 63]}, {32'h1124, 32'h2224});
    check(lg_ctla[(m + 1) & 63] == 32'h08 && lg_ctlb[(m + 1) & 63] == 32'hC2, "R11 controls from descriptor",
          {lg_ctla[(m + 1) & 63], lg_ctlb[(m + 1) & 63]}, {32'h08, 32'hC2});
    src_mode = 2'b00; dst_mode = 2'b00;
  endtask

  initial begin
    t_reset();
    t_zero();
    t_single();
    t_chain();
    t_replay();
    t_contig();
    finish_up();
  end
endmodule